// File: doc/BRIEF.md
# Dual Decrementer Timer Unit

This block supplies the countdown timers and the utilization counter for one processor core. It holds two independent down-counters: one serves the supervisor and one serves the hypervisor. It also holds a wide up-counter that measures processor utilization. All three counters move only when the shared timebase tick enable is high. The timebase generator sits outside this block.

Each decrementer drives its own interrupt request. The request is raised when the sign bit of the count changes from 0 to 1. That change happens in two ways. The first is counting down through zero, after which the count carries on from all ones. The second is software writing a negative value while the count is still non-negative. Requests are sticky: each one is held until its own acknowledge input clears it.

Software reaches all counters through a small single-cycle register port. The port has a 2-bit select, a write enable, write data, and combinational read data. The asynchronous reset loads both decrementers with all ones, clears the utilization counter and drops both requests. Loading all ones is not a sign transition, so reset raises no request.

Top module: `dual_dec_timer`

## Requirements
- R1: After reset both decrementers read 0xFFFFFFFF, the utilization counter reads zero and both interrupt outputs are low.
- R2: `rd_data` shows the register picked by `sel` in the same cycle: 0 gives the supervisor decrementer, 1 the hypervisor decrementer, 2 the upper 32 bits of the utilization counter and 3 its lower 32 bits.
- R3: A decrementer drops by exactly one on each cycle in which `tick` is high and it is not written. It holds its value when `tick` is low.
- R4: A tick taken while a decrementer holds zero loads 0xFFFFFFFF and raises that decrementer's interrupt.
- R5: A write with `wr_en` high loads `wr_data` into the selected counter on the next clock edge. The write takes priority over a tick in the same cycle, so that tick is not applied to that counter.
- R6: A write whose bit 31 is 1 raises the interrupt if the old count had bit 31 clear. A write of a non-negative value raises no interrupt, and neither does a negative write over a count that is already negative.
- R7: An interrupt output stays high until its acknowledge input is sampled high. If a new raise event and the acknowledge fall in the same cycle, the raise wins and the output stays high.
- R8: The two decrementers are independent. A write, expiry or acknowledge on one changes neither the count nor the interrupt of the other.
- R9: The utilization counter rises by one per tick across its full 64 bits, with the carry passing from the lower half into the upper half.
- R10: A write to one half of the utilization counter replaces that half and keeps the other half. No tick is applied to the counter in that cycle.
- R11: Writing zero to a decrementer makes it expire on the first following tick, never in the cycle of the write itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| tick | input | 1 | Timebase tick enable shared by all counters |
| sel | input | 2 | Register select (0 supervisor, 1 hypervisor, 2 utilization high, 3 utilization low) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register |
| ack_sup | input | 1 | Clears the supervisor interrupt |
| ack_hyp | input | 1 | Clears the hypervisor interrupt |
| irq_sup | output | 1 | Sticky supervisor decrementer interrupt |
| irq_hyp | output | 1 | Sticky hypervisor decrementer interrupt |

## Verification
Two pairs of events can land in the same cycle.

- **Write and tick.** The bench issues a write in the same cycle as a tick. It then checks that the new count equals the written value and not that value minus one. It also checks that the utilization half that was written takes no increment.
- **Raise and acknowledge.** During the write sweep, every write is issued with both acknowledges high. A negative write or an expiry in that cycle must leave the interrupt set. Every other acknowledge must clear it.

All expected counts and interrupt levels come from a running arithmetic model in the bench. The bench compares the model against every register readback after every cycle.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [1:0] {
    SEL_SUP = 2'd0,
    SEL_HYP = 2'd1,
    SEL_UHI = 2'd2,
    SEL_ULO = 2'd3
  } dt_sel_e;
endpackage

// File: rtl/dt_dec.sv
// One down-counter with a sign-transition interrupt latch.
module dt_dec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         ack,
  output logic [W-1:0] count,
  output logic         irq
);
  localparam int MSB = W - 1;

  logic [W-1:0] cnt_nxt;
  logic         cnt_en;
  logic         expire;
  logic         neg_load;
  logic         irq_nxt;

  always_comb begin
    cnt_en   = load | tick;
    cnt_nxt  = load ? load_val : (count - {{(W-1){1'b0}}, 1'b1});
    expire   = tick & ~load & (count == '0);
    neg_load = load & load_val[MSB] & ~count[MSB];
    if (expire | neg_load)
      irq_nxt = 1'b1;
    else if (ack)
      irq_nxt = 1'b0;
    else
      irq_nxt = irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '1;
      irq   <= 1'b0;
    end else begin
      if (cnt_en)
        count <= cnt_nxt;
      irq <= irq_nxt;
    end
  end
endmodule

// File: rtl/dt_util.sv
// Utilization up-counter with half-word loads.
module dt_util #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_hi,
  input  logic           wr_lo,
  input  logic [W/2-1:0] wr_val,
  output logic [W-1:0]   count
);
  localparam int HW = W / 2;

  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en = tick | wr_hi | wr_lo;
    if (wr_hi)
      cnt_nxt = {wr_val, count[HW-1:0]};
    else if (wr_lo)
      cnt_nxt = {count[W-1:HW], wr_val};
    else
      cnt_nxt = count + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (cnt_en)
      count <= cnt_nxt;
  end
endmodule

// File: rtl/dual_dec_timer.sv
module dual_dec_timer
  import dt_pkg::*;
#(
  parameter int DEC_W  = 32,
  parameter int UTIL_W = 2 * DEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       sel,
  input  logic             wr_en,
  input  logic [DEC_W-1:0] wr_data,
  output logic [DEC_W-1:0] rd_data,
  input  logic             ack_sup,
  input  logic             ack_hyp,
  output logic             irq_sup,
  output logic             irq_hyp
);
  localparam int NDEC = 2;
  localparam int HW   = UTIL_W / 2;

  logic [DEC_W-1:0]  dec_cnt [NDEC];
  logic [NDEC-1:0]   dec_load;
  logic [NDEC-1:0]   dec_ack;
  logic [NDEC-1:0]   dec_irq;
  logic [DEC_W-1:0]  sup_count;
  logic [DEC_W-1:0]  hyp_count;
  logic [UTIL_W-1:0] util_count;
  dt_sel_e           sel_e;

  assign sel_e       = dt_sel_e'(sel);
  assign dec_load[0] = wr_en & (sel_e == SEL_SUP);
  assign dec_load[1] = wr_en & (sel_e == SEL_HYP);
  assign dec_ack     = {ack_hyp, ack_sup};

  for (genvar i = 0; i < NDEC; i++) begin : g_dec
    dt_dec #(.W(DEC_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (dec_load[i]),
      .load_val (wr_data),
      .ack      (dec_ack[i]),
      .count    (dec_cnt[i]),
      .irq      (dec_irq[i])
    );
  end

  assign sup_count = dec_cnt[0];
  assign hyp_count = dec_cnt[1];
  assign irq_sup   = dec_irq[0];
  assign irq_hyp   = dec_irq[1];

  dt_util #(.W(UTIL_W)) u_util (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_hi  (wr_en & (sel_e == SEL_UHI)),
    .wr_lo  (wr_en & (sel_e == SEL_ULO)),
    .wr_val (wr_data[HW-1:0]),
    .count  (util_count)
  );

  always_comb begin
    unique case (sel_e)
      SEL_SUP: rd_data = sup_count;
      SEL_HYP: rd_data = hyp_count;
      SEL_UHI: rd_data = util_count[UTIL_W-1:HW];
      default: rd_data = util_count[HW-1:0];
    endcase
  end
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
  parameter int DEC_W  = 32,
  parameter int UTIL_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [1:0]        sel,
  input logic              wr_en,
  input logic [DEC_W-1:0]  wr_data,
  input logic              ack_sup,
  input logic              ack_hyp,
  input logic              irq_sup,
  input logic              irq_hyp,
  input logic [DEC_W-1:0]  sup_cnt,
  input logic [DEC_W-1:0]  hyp_cnt,
  input logic [UTIL_W-1:0] util_cnt
);
  logic wr_sup, wr_hyp, wr_util;
  assign wr_sup  = wr_en && sel == 2'd0;
  assign wr_hyp  = wr_en && sel == 2'd1;
  assign wr_util = wr_en && sel[1];

  // R5
  sup_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sup |=> sup_cnt == $past(wr_data));
  // R3
  sup_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_sup |=> sup_cnt == $past(sup_cnt) - 1'b1);
  // R3
  hyp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_hyp |=> $stable(hyp_cnt));
  // R4
  sup_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_sup && sup_cnt == '0 |=> irq_sup);
  // R6
  hyp_neg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hyp && wr_data[DEC_W-1] && !hyp_cnt[DEC_W-1] |=> irq_hyp);
  // R7
  sup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sup && !ack_sup |=> irq_sup);
  // R7
  hyp_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_hyp) |-> $past(ack_hyp));
  // R8
  sup_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sup) |-> $past(wr_sup || (tick && sup_cnt == '0)));
  // R9
  util_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_util |=> util_cnt == $past(util_cnt) + 1'b1);
endmodule

bind dual_dec_timer dt_checker #(.DEC_W(DEC_W), .UTIL_W(UTIL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .sel      (sel),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .ack_sup  (ack_sup),
  .ack_hyp  (ack_hyp),
  .irq_sup  (irq_sup),
  .irq_hyp  (irq_hyp),
  .sup_cnt  (sup_count),
  .hyp_cnt  (hyp_count),
  .util_cnt (util_count)
);

// File: tb/tb_dual_dec_timer.sv
`timescale 1ns/100ps
module tb_dual_dec_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, wr_en, ack_sup, ack_hyp;
  logic [1:0]  sel;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq_sup, irq_hyp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_sup, m_hyp;
  logic [63:0] m_util;
  logic        m_isup, m_ihyp;

  always #2.5 clk = ~clk;

  dual_dec_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ack_sup(ack_sup),
    .ack_hyp(ack_hyp), .irq_sup(irq_sup), .irq_hyp(irq_hyp)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Read every register through the port and compare with the model (R2).
  task automatic check_all(input string req);
    sel = 2'd0; #0.2; chk({req, " R2 sup"}, 64'(rd_data), 64'(m_sup));
    sel = 2'd1; #0.2; chk({req, " R2 hyp"}, 64'(rd_data), 64'(m_hyp));
    sel = 2'd2; #0.2; chk({req, " R2 uhi"}, 64'(rd_data), 64'(m_util[63:32]));
    sel = 2'd3; #0.2; chk({req, " R2 ulo"}, 64'(rd_data), 64'(m_util[31:0]));
    chk({req, " irq_sup"}, 64'(irq_sup), 64'(m_isup));
    chk({req, " irq_hyp"}, 64'(irq_hyp), 64'(m_ihyp));
  endtask

  // One clock: drive, advance the model per the requirements, wait past the edge.
  task automatic cyc(input logic t, input logic w, input logic [1:0] s,
                     input logic [31:0] d, input logic as, input logic ah);
    logic ws, wh, set_s, set_h;
    tick = t; wr_en = w; sel = s; wr_data = d; ack_sup = as; ack_hyp = ah;
    ws = w && s == 2'd0;
    wh = w && s == 2'd1;
    set_s = (ws && d[31] && !m_sup[31]) || (t && !ws && m_sup == 32'd0);
    set_h = (wh && d[31] && !m_hyp[31]) || (t && !wh && m_hyp == 32'd0);
    m_isup = set_s ? 1'b1 : (as ? 1'b0 : m_isup);
    m_ihyp = set_h ? 1'b1 : (ah ? 1'b0 : m_ihyp);
    m_sup  = ws ? d : (t ? m_sup - 32'd1 : m_sup);
    m_hyp  = wh ? d : (t ? m_hyp - 32'd1 : m_hyp);
    if (w && s == 2'd2)      m_util = {d, m_util[31:0]};
    else if (w && s == 2'd3) m_util = {m_util[63:32], d};
    else if (t)              m_util = m_util + 64'd1;
    @(posedge clk); #1;
    tick = 0; wr_en = 0; ack_sup = 0; ack_hyp = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [8];
    vals = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h7FFFFFFF, 32'h80000000,
             32'h80000001, 32'hFFFFFFFF};
    rst_n = 0; tick = 0; wr_en = 0; sel = 0; wr_data = 0; ack_sup = 0; ack_hyp = 0;
    m_sup = '1; m_hyp = '1; m_util = '0; m_isup = 0; m_ihyp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check_all("R1 reset");

    // Sweep boundary values into each decrementer; write with both acks (R7 raise wins).
    for (int tgt = 0; tgt < 2; tgt++) begin
      for (int k = 0; k < 8; k++) begin
        cyc(0, 1, 2'(tgt), vals[k], 1, 1);
        check_all("R5 R6 R7 write");
        for (int n = 0; n < 5; n++) begin
          cyc(1, 0, 0, 0, 0, 0);
          check_all("R3 R4 R11 R8 tick");
        end
      end
    end

    // R11: zero write raises nothing at once, expires on first tick.
    cyc(0, 1, 2'd0, 32'd0, 1, 1);
    chk("R11 no irq at write", 64'(irq_sup), 64'd0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R11 idle hold", 64'(irq_sup), 64'd0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R11 expire", 64'(irq_sup), 64'd1);
    check_all("R4 R11 wrap");

    // R7: sticky through idle and ticks, cleared by ack only.
    for (int n = 0; n < 4; n++) begin
      cyc(n[0], 0, 0, 0, 0, 0);
      check_all("R7 sticky");
    end
    cyc(0, 0, 0, 0, 1, 0);
    check_all("R7 ack clears");
    chk("R7 sup low", 64'(irq_sup), 64'd0);

    // R5: write and tick in the same cycle, write wins.
    cyc(1, 1, 2'd0, 32'd100, 0, 0);
    check_all("R5 write vs tick");
    cyc(1, 1, 2'd1, 32'd7, 0, 0);
    check_all("R5 write vs tick hyp");

    // R6: negative write over negative count raises nothing.
    cyc(0, 1, 2'd0, 32'h80000000, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 1, 2'd0, 32'hC0000000, 0, 0);
    check_all("R6 neg over neg");

    // R9/R10: utilization carry and half writes.
    cyc(0, 1, 2'd2, 32'h00000005, 0, 0);
    cyc(0, 1, 2'd3, 32'hFFFFFFFD, 0, 0);
    check_all("R10 half writes");
    for (int n = 0; n < 5; n++) begin
      cyc(1, 0, 0, 0, 0, 0);
      check_all("R9 carry");
    end
    cyc(1, 1, 2'd3, 32'h12345678, 0, 0);
    check_all("R10 low write vs tick");
    cyc(1, 1, 2'd2, 32'hFFFFFFFF, 0, 0);
    check_all("R10 high write vs tick");
    cyc(0, 1, 2'd3, 32'hFFFFFFFF, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    check_all("R9 full wrap");

    // R8: mixed traffic on both lines.
    cyc(0, 1, 2'd0, 32'd3, 1, 1);
    cyc(0, 1, 2'd1, 32'd1, 0, 0);
    for (int i = 0; i < 40; i++) begin
      cyc(1'(i % 3 != 0), 1'(i % 11 == 5), 2'(i % 4), 32'(i % 3),
          1'(i % 7 == 0), 1'(i % 5 == 0));
      check_all("R8 mixed");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule